// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block puts a small on-chip word memory behind one shared access port and lets several requesters run indivisible read-modify-write operations on it. Every requester presents its own valid signal with an opcode, a word address and two operands. A round-robin arbiter picks one request at a time. The chosen request is then read, updated and written back in a single execute cycle, so no other access can fall in the middle of it. The result comes back on one shared response channel, tagged with the requester index.

The unit supports plain load and store, test-and-set, swap, fetch-and-add, compare-and-swap, and a linked-load / conditional-store pair. Each requester owns one reservation entry. The entry holds the address of that requester's last linked load and a valid flag. The flag is dropped when a different requester writes that word, when the snoop input reports an outside write or an eviction of that word, or when the owner issues a conditional store. A conditional store writes memory only while its reservation is intact. Software builds spin locks, tickets and barrier counters on top of these operations. A plain store acts as the lock release.

Opcode encoding on each 3-bit opcode lane: 0 load, 1 store, 2 test-and-set, 3 swap, 4 fetch-and-add, 5 compare-and-swap, 6 linked load, 7 conditional store.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every memory word reads 0 and no reservation is valid, so a conditional store (opcode 7) issued before any linked load returns 0.
- R2: Test-and-set (opcode 2) returns the old word and leaves the word equal to 1.
- R3: Swap (opcode 3) returns the old word and leaves operand A in the word.
- R4: Fetch-and-add (opcode 4) returns the old word and leaves (old + operand A) modulo 2^DW in the word.
- R5: Compare-and-swap (opcode 5) returns the old word. It writes operand B only when the old word equals operand A, and otherwise leaves the word unchanged.
- R6: Load (opcode 0) returns the word and leaves it unchanged. Store (opcode 1) writes operand A and returns the old word.
- R7: Linked load (opcode 6) returns the word without changing it and records the address in the issuing requester's reservation.
- R8: Conditional store (opcode 7) succeeds only when the issuer holds a valid reservation for that same address. On success it writes operand A and returns 1. On failure it returns 0 and the memory is left unchanged.
- R9: Any write by one requester clears the reservations of the other requesters that hold the same address. Reservations on other addresses survive.
- R10: A snoop pulse clears every reservation on the snooped address, including one set by a linked load that executes in the same cycle.
- R11: A conditional store clears the issuer's own reservation whether or not it succeeds.
- R12: At most one ready bit is high at a time, and ready is only given to a valid requester. Grants rotate round-robin, starting after the last granted requester.
- R13: A request is accepted on the clock edge where its ready is high. It executes on the next edge, and its response is valid during the cycle after that execute edge. No request is accepted during its execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | One request-valid bit per requester |
| req_ready | output | NREQ | Accept strobe, at most one bit high |
| req_op | input | 3*NREQ | Opcode lanes, requester i at bits 3i+2..3i |
| req_addr | input | AW*NREQ | Word address lanes |
| req_opa | input | DW*NREQ | Operand A lanes (store data, addend, compare value) |
| req_opb | input | DW*NREQ | Operand B lanes (compare-and-swap new value) |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_id | output | IDW | Requester index of the response |
| rsp_data | output | DW | Old word, or 1/0 success flag for a conditional store |
| snp_valid | input | 1 | External write or eviction notice |
| snp_addr | input | AW | Address of the snoop notice |

## Verification
The assertions assume that a requester keeps its request fields steady while valid is high. They also assume that the snoop input is only a pulse qualified by snp_valid and carries no meaning when valid is low, and that reset is held for at least one clock edge. The stimulus changes every request lane only at falling edges. It drops a lane's valid on the falling edge after acceptance and never changes a lane while it waits. It pulses the snoop input for exactly one cycle, at a time when the unit is idle. With those inputs, the reservation properties can refer to the previous cycle's snoop address and executing address without any ambiguity.

// File: rtl/amu_pkg.sv
package amu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_FADD  = 3'd4,
    OP_CAS   = 3'd5,
    OP_LL    = 3'd6,
    OP_SC    = 3'd7
  } amu_op_e;

  localparam int OPW = 3;

endpackage

// File: rtl/amu_word_mem.sv
module amu_word_mem #(
  parameter int AW = 3,
  parameter int DW = 16,
  localparam int NW = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] words [NW];

  assign rdata = words[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) words[i] <= '0;
    end else if (we) begin
      words[waddr] <= wdata;
    end
  end

endmodule

// File: rtl/amu_link_table.sv
module amu_link_table #(
  parameter int NREQ = 4,
  parameter int AW   = 3,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec,
  input  logic [IDW-1:0]   id,
  input  logic [AW-1:0]    addr,
  input  logic             set_link,
  input  logic             drop_own,
  input  logic             wr,
  input  logic             snp_valid,
  input  logic [AW-1:0]    snp_addr,
  output logic             sc_ok,
  output logic [NREQ-1:0]  link_vld,
  output logic [NREQ*AW-1:0] link_addr_flat
);

  logic [AW-1:0]   lad    [NREQ];
  logic [AW-1:0]   lad_nx [NREQ];
  logic [NREQ-1:0] vld_nx;

  assign sc_ok = link_vld[id] && (lad[id] == addr);

  always_comb begin
    vld_nx = link_vld;
    for (int j = 0; j < NREQ; j++) begin
      lad_nx[j] = lad[j];
      if (exec && wr && (IDW'(j) != id) && (lad[j] == addr)) vld_nx[j] = 1'b0;
      if (exec && (IDW'(j) == id)) begin
        if (set_link) begin
          vld_nx[j] = 1'b1;
          lad_nx[j] = addr;
        end
        if (drop_own) vld_nx[j] = 1'b0;
      end
      if (snp_valid && (lad_nx[j] == snp_addr)) vld_nx[j] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_vld <= '0;
      for (int j = 0; j < NREQ; j++) lad[j] <= '0;
    end else begin
      link_vld <= vld_nx;
      for (int j = 0; j < NREQ; j++) lad[j] <= lad_nx[j];
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_flat
    assign link_addr_flat[g*AW +: AW] = lad[g];
  end

endmodule

// File: rtl/amu_rr_arbiter.sv
module amu_rr_arbiter #(
  parameter int NREQ = 4,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            adv,
  output logic [NREQ-1:0] gnt,
  output logic [IDW-1:0]  gnt_idx,
  output logic            gnt_any
);

  logic [IDW-1:0] ptr_q;

  always_comb begin : p_pick
    int j;
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 0; k < NREQ; k++) begin
      j = (int'(ptr_q) + k) % NREQ;
      if (!gnt_any && req[j]) begin
        gnt_any = 1'b1;
        gnt_idx = IDW'(j);
        gnt[j]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (adv) ptr_q <= (int'(gnt_idx) == NREQ - 1) ? '0 : gnt_idx + 1'b1;
  end

endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import amu_pkg::*;
#(
  parameter int NREQ = 4,
  parameter int AW   = 3,
  parameter int DW   = 16,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      req_valid,
  output logic [NREQ-1:0]      req_ready,
  input  logic [NREQ*OPW-1:0]  req_op,
  input  logic [NREQ*AW-1:0]   req_addr,
  input  logic [NREQ*DW-1:0]   req_opa,
  input  logic [NREQ*DW-1:0]   req_opb,
  output logic                 rsp_valid,
  output logic [IDW-1:0]       rsp_id,
  output logic [DW-1:0]        rsp_data,
  input  logic                 snp_valid,
  input  logic [AW-1:0]        snp_addr
);

  // {write enable, write data, response data}
  function automatic logic [2*DW:0] amu_eval(amu_op_e op, logic [DW-1:0] old,
                                             logic [DW-1:0] a, logic [DW-1:0] b,
                                             logic ok);
    logic          w;
    logic [DW-1:0] nv;
    logic [DW-1:0] rv;
    w  = 1'b0;
    nv = old;
    rv = old;
    case (op)
      OP_STORE: begin w = 1'b1; nv = a; end
      OP_TAS:   begin w = 1'b1; nv = DW'(1); end
      OP_SWAP:  begin w = 1'b1; nv = a; end
      OP_FADD:  begin w = 1'b1; nv = old + a; end
      OP_CAS:   begin w = (old == a); nv = b; end
      OP_SC:    begin w = ok; nv = a; rv = DW'(ok); end
      default:  begin w = 1'b0; end
    endcase
    return {w, nv, rv};
  endfunction

  logic [NREQ-1:0] gnt;
  logic [IDW-1:0]  gnt_idx;
  logic            gnt_any;
  logic            fire;
  logic            busy_q;
  logic [IDW-1:0]  id_q;
  amu_op_e         op_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   opa_q, opb_q;
  logic [DW-1:0]   word_rd;
  logic            sc_ok;
  logic [2*DW:0]   eval_r;
  logic            mem_we;
  logic            exec_sc;
  logic [NREQ-1:0] link_vld;
  logic [NREQ*AW-1:0] link_addr_flat;

  amu_rr_arbiter #(.NREQ(NREQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .adv(fire),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
  );

  assign fire      = gnt_any && !busy_q;
  assign req_ready = busy_q ? '0 : gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      id_q   <= '0;
      op_q   <= OP_LOAD;
      addr_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
    end else begin
      busy_q <= fire;
      if (fire) begin
        id_q   <= gnt_idx;
        op_q   <= amu_op_e'(req_op[gnt_idx*OPW +: OPW]);
        addr_q <= req_addr[gnt_idx*AW +: AW];
        opa_q  <= req_opa[gnt_idx*DW +: DW];
        opb_q  <= req_opb[gnt_idx*DW +: DW];
      end
    end
  end

  amu_word_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(addr_q),
    .wdata(eval_r[2*DW-1:DW]), .raddr(addr_q), .rdata(word_rd)
  );

  amu_link_table #(.NREQ(NREQ), .AW(AW)) u_link (
    .clk(clk), .rst_n(rst_n), .exec(busy_q), .id(id_q), .addr(addr_q),
    .set_link(op_q == OP_LL), .drop_own(op_q == OP_SC), .wr(mem_we),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .sc_ok(sc_ok), .link_vld(link_vld), .link_addr_flat(link_addr_flat)
  );

  assign eval_r  = amu_eval(op_q, word_rd, opa_q, opb_q, sc_ok);
  assign mem_we  = busy_q && eval_r[2*DW];
  assign exec_sc = busy_q && (op_q == OP_SC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= busy_q;
      if (busy_q) begin
        rsp_id   <= id_q;
        rsp_data <= eval_r[DW-1:0];
      end
    end
  end

endmodule

// File: rtl/amu_chk.sv
module amu_chk #(
  parameter int NREQ = 4,
  parameter int AW   = 3,
  localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREQ-1:0]    req_valid,
  input logic [NREQ-1:0]    req_ready,
  input logic               fire,
  input logic               busy,
  input logic               rsp_valid,
  input logic               exec_sc,
  input logic               sc_ok,
  input logic               mem_we,
  input logic [IDW-1:0]     id_q,
  input logic [AW-1:0]      addr_q,
  input logic               snp_valid,
  input logic [AW-1:0]      snp_addr,
  input logic [NREQ-1:0]    link_vld,
  input logic [NREQ*AW-1:0] link_addr_flat
);

  // R12
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R12
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R13
  exec_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> busy);

  // R13
  rsp_after_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rsp_valid);

  // R13
  no_accept_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (req_ready == '0));

  // R8
  sc_fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_sc && !sc_ok) |-> !mem_we);

  for (genvar j = 0; j < NREQ; j++) begin : g_res
    // R10
    snoop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |=> !(link_vld[j] && (link_addr_flat[j*AW +: AW] == $past(snp_addr))));

    // R9
    other_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && (id_q != IDW'(j))) |=>
        !(link_vld[j] && (link_addr_flat[j*AW +: AW] == $past(addr_q))));

    // R11
    sc_drops_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_sc && (id_q == IDW'(j))) |=> !link_vld[j]);
  end

endmodule

bind atomic_mem_unit amu_chk #(.NREQ(NREQ), .AW(AW)) u_amu_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .fire(fire), .busy(busy_q), .rsp_valid(rsp_valid), .exec_sc(exec_sc),
  .sc_ok(sc_ok), .mem_we(mem_we), .id_q(id_q), .addr_q(addr_q),
  .snp_valid(snp_valid), .snp_addr(snp_addr), .link_vld(link_vld),
  .link_addr_flat(link_addr_flat)
);

// File: tb/test_atomic_mem_unit.sv
`timescale 1ns/1ps
module test_atomic_mem_unit;

  localparam int NREQ = 4;
  localparam int AW   = 3;
  localparam int DW   = 16;
  localparam int IDW  = 2;
  localparam int NW   = 1 << AW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NREQ-1:0]      req_valid = '0;
  logic [NREQ-1:0]      req_ready;
  logic [NREQ*3-1:0]    req_op = '0;
  logic [NREQ*AW-1:0]   req_addr = '0;
  logic [NREQ*DW-1:0]   req_opa = '0;
  logic [NREQ*DW-1:0]   req_opb = '0;
  logic                 rsp_valid;
  logic [IDW-1:0]       rsp_id;
  logic [DW-1:0]        rsp_data;
  logic                 snp_valid = 1'b0;
  logic [AW-1:0]        snp_addr = '0;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mmem [NW];
  logic          mlv  [NREQ];
  logic [AW-1:0] mla  [NREQ];
  int order [8];
  int ocnt = 0;

  always #4 clk = ~clk;

  atomic_mem_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) i_atomic_mem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input int id, input int op, input int addr,
                        input logic [DW-1:0] a, input logic [DW-1:0] b,
                        output logic [DW-1:0] data);
    @(negedge clk);
    req_op[id*3 +: 3]     = 3'(op);
    req_addr[id*AW +: AW] = AW'(addr);
    req_opa[id*DW +: DW]  = a;
    req_opb[id*DW +: DW]  = b;
    req_valid[id]         = 1'b1;
    #1;
    while (!req_ready[id]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[id] = 1'b0;
    do @(negedge clk); while (!(rsp_valid && int'(rsp_id) == id));
    data = rsp_data;
    order[ocnt % 8] = id;
    ocnt++;
  endtask

  // independent reference of the operation and its effect on reservations
  task automatic run_op(input string req, input int id, input int op, input int addr,
                        input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] old, exp_r, got;
    logic          wr;
    logic [DW-1:0] nv;
    old = mmem[addr];
    wr = 1'b0; nv = old; exp_r = old;
    case (op)
      1: begin wr = 1; nv = a; end
      2: begin wr = 1; nv = 1; end
      3: begin wr = 1; nv = a; end
      4: begin wr = 1; nv = DW'(int'(old) + int'(a)); end
      5: begin wr = (old == a); nv = b; end
      7: begin wr = mlv[id] && (int'(mla[id]) == addr); nv = a; exp_r = DW'(wr); end
      default: ;
    endcase
    do_req(id, op, addr, a, b, got);
    check(got == exp_r, req, int'(got), int'(exp_r));
    if (wr) begin
      mmem[addr] = nv;
      for (int j = 0; j < NREQ; j++)
        if (j != id && int'(mla[j]) == addr) mlv[j] = 0;
    end
    if (op == 6) begin mlv[id] = 1; mla[id] = AW'(addr); end
    if (op == 7) mlv[id] = 0;
  endtask

  task automatic snoop(input int addr);
    @(negedge clk);
    snp_valid = 1'b1;
    snp_addr  = AW'(addr);
    @(negedge clk);
    snp_valid = 1'b0;
    for (int j = 0; j < NREQ; j++) if (int'(mla[j]) == addr) mlv[j] = 0;
  endtask

  task automatic rr_burst(input int first);
    ocnt = 0;
    for (int i = 0; i < NREQ; i++) begin
      fork
        automatic int k = i;
        begin
          logic [DW-1:0] d;
          do_req(k, 0, k, '0, '0, d);
        end
      join_none
    end
    wait fork;
    for (int i = 0; i < NREQ; i++)
      check(order[i] == (first + i) % NREQ, "R12 round-robin order", order[i], (first + i) % NREQ);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NW; i++) mmem[i] = '0;
    for (int j = 0; j < NREQ; j++) begin mlv[j] = 0; mla[j] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
    check(req_ready == '0, "R13 no ready without valid", int'(req_ready), 0);

    // R1: memory clear and no reservation after reset
    for (int a = 0; a < NW; a++) run_op("R1 reset word", a % NREQ, 0, a, '0, '0);
    run_op("R1 SC before any LL fails", 0, 7, 0, 16'h55, '0);
    run_op("R1 word untouched by failed SC", 1, 0, 0, '0, '0);

    // sweep of all data operations over every address
    for (int a = 0; a < NW; a++) begin
      automatic int r = a % NREQ;
      automatic logic [DW-1:0] v = DW'(a * 16'h1111 + 16'h0f0f);
      run_op("R6 store", r, 1, a, v, '0);
      run_op("R6 load", (r + 1) % NREQ, 0, a, '0, '0);
      run_op("R4 fetch-add", r, 4, a, DW'(a + 3), '0);
      run_op("R3 swap", (r + 2) % NREQ, 3, a, ~v, '0);
      run_op("R5 CAS miss", r, 5, a, v, 16'h1234);
      run_op("R5 CAS hit", r, 5, a, ~v, DW'(a * 7));
      run_op("R2 test-and-set", (r + 3) % NREQ, 2, a, '0, '0);
      run_op("R2 test-and-set again", r, 2, a, '0, '0);
    end
    // R4: wrap around the word width
    run_op("R4 store max", 0, 1, 5, 16'hffff, '0);
    run_op("R4 fetch-add wraps", 1, 4, 5, 16'h0002, '0);
    run_op("R4 wrapped value", 2, 0, 5, '0, '0);

    // R7/R8: LL then SC succeeds, memory takes operand A
    run_op("R7 linked load", 0, 6, 2, '0, '0);
    run_op("R8 SC success", 0, 7, 2, 16'h00a5, '0);
    run_op("R8 SC wrote word", 1, 0, 2, '0, '0);
    // R11: second SC without fresh LL fails
    run_op("R11 SC after SC fails", 0, 7, 2, 16'h0bad, '0);
    run_op("R11 word kept", 1, 0, 2, '0, '0);
    // R9: another requester's store to the linked word breaks the link
    run_op("R7 linked load", 1, 6, 3, '0, '0);
    run_op("R9 other store same addr", 2, 1, 3, 16'h0033, '0);
    run_op("R9 SC after conflicting write fails", 1, 7, 3, 16'h0077, '0);
    run_op("R8 failed SC leaves memory", 0, 0, 3, '0, '0);
    // R9: write to a different address keeps the link
    run_op("R7 linked load", 1, 6, 4, '0, '0);
    run_op("R9 other store other addr", 2, 1, 6, 16'h0066, '0);
    run_op("R9 SC survives unrelated write", 1, 7, 4, 16'h0044, '0);
    // R8: SC to an address other than the linked one fails
    run_op("R7 linked load", 3, 6, 1, '0, '0);
    run_op("R8 SC wrong address fails", 3, 7, 7, 16'h0099, '0);
    run_op("R8 wrong-address word kept", 0, 0, 7, '0, '0);
    // R10: snoop clears the reservation, an unrelated snoop does not
    run_op("R7 linked load", 2, 6, 0, '0, '0);
    snoop(0);
    run_op("R10 SC after snoop fails", 2, 7, 0, 16'h00cc, '0);
    run_op("R7 linked load", 2, 6, 0, '0, '0);
    snoop(5);
    run_op("R10 SC after unrelated snoop", 2, 7, 0, 16'h00dd, '0);
    // R9: atomic (fetch-add) by another requester also breaks the link
    run_op("R7 linked load", 3, 6, 6, '0, '0);
    run_op("R9 other fetch-add", 0, 4, 6, 16'h0001, '0);
    run_op("R9 SC after atomic fails", 3, 7, 6, 16'h0abc, '0);

    // R12: round-robin order under full contention
    run_op("R12 align pointer", 3, 0, 0, '0, '0);
    rr_burst(0);
    run_op("R12 move pointer", 1, 0, 0, '0, '0);
    rr_burst(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule